// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a bank of eight hardware semaphore flags that sit beside, but apart from, a shared memory array. Two agents, a left port and a right port, use them to claim and hand back shared resources. A port selects the bank by pulling its semaphore select low while keeping its memory enable inactive. The low three address bits then pick one flag, and read/write chooses the operation. A write carries its meaning in data bit 0 alone: a zero asks for the flag, a one gives it back or withdraws a waiting request.

Each side sees ownership as the complement of the other. The holder reads zero and the other port reads one. A port that asks while the other side holds the flag is remembered, and it takes the flag in the same cycle the holder lets go. A read copies the flag state onto every data line and captures it in an output register. The value then stays put until that port's next read, whatever the other port writes in the meantime.

Top module: `sem_latch_bank`

## Requirements
- R1: After reset every flag is free, no request is waiting, and both read-data buses hold all ones.
- R2: A port reaches the bank only in a cycle where its semaphore select is low and its memory enable (active low) is high. Any other cycle changes no flag and leaves that port's read data as it was.
- R3: Address bits above bit 2 and data bits above bit 0 have no effect on which flag is addressed or on what a write does.
- R4: A port that writes 0 to a free flag becomes its holder. That port then reads 0 at that address and the other port reads 1.
- R5: A write of 1 from a port that is not the holder does not take the flag from the holder.
- R6: When the holder writes 1 and no request from the other side is waiting, the flag becomes free and both sides read 1.
- R7: If the non-holder wrote 0 while the flag was held, that port becomes holder in the same cycle the holder writes 1.
- R8: A non-holder that wrote 0 and then writes 1 withdraws its request, so a later release leaves the flag free.
- R9: A read drives the addressed port's view (0 for holder, 1 otherwise) on every data bit, registered one cycle after the read cycle. The value is taken from the state before that cycle's writes and holds until the same port reads again.
- R10: When both ports write 0 to the same free flag in the same cycle, the left port becomes holder.
- R11: The eight flags operate independently. An operation on one address never changes another flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory enable, active low; must be high for a semaphore access |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_addr | input | ADDR_W (16) | Left address; low 3 bits pick the flag |
| l_wdata | input | DATA_W (18) | Left write data; bit 0 used |
| l_rdata | output | DATA_W (18) | Left registered read data |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory enable, active low; must be high for a semaphore access |
| r_we_n | input | 1 | Right write strobe, low = write, high = read |
| r_addr | input | ADDR_W (16) | Right address; low 3 bits pick the flag |
| r_wdata | input | DATA_W (18) | Right write data; bit 0 used |
| r_rdata | output | DATA_W (18) | Right registered read data |

## Verification
The bench builds the block with its default parameters: eight flags, a 16-bit address and an 18-bit data bus. Every flag can therefore be walked through acquire, conflicting request, handover, withdrawal and same-cycle tie from both sides. Garbage in the upper address and data bits is held during every such walk. A long pseudo-random run then mixes reads, writes and blocked accesses on both ports over all eight addresses. Each registered read result is compared with an arithmetic model of holder and request flags.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int SEL_W   = 3
) (
  input  logic               sem_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_SEM-1:0] wr_hot,
  output logic               rd_en
);
  logic access;
  logic wr_en;

  // bank reached only with select low and memory enable inactive
  assign access = !sem_n && ce_n;
  assign wr_en  = access && !we_n;
  assign rd_en  = access && we_n;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_hot
    assign wr_hot[g] = wr_en && (sel == SEL_W'(g));
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic bit_l,
  input  logic wr_r,
  input  logic bit_r,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);
  logic       req_l_q, req_l_d;
  logic       req_r_q, req_r_d;
  sem_owner_e owner_q, owner_d;

  always_comb begin
    req_l_d = wr_l ? !bit_l : req_l_q;
    req_r_d = wr_r ? !bit_r : req_r_q;
    owner_d = owner_q;
    unique case (owner_q)
      OWN_LEFT: begin
        if (!req_l_d) owner_d = req_r_d ? OWN_RIGHT : OWN_NONE;
      end
      OWN_RIGHT: begin
        if (!req_r_d) owner_d = req_l_d ? OWN_LEFT : OWN_NONE;
      end
      default: begin
        // left wins a same-cycle tie
        if (req_l_d)      owner_d = OWN_LEFT;
        else if (req_r_d) owner_d = OWN_RIGHT;
        else              owner_d = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      owner_q <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      owner_q <= owner_d;
    end
  end

  assign own_l  = (owner_q == OWN_LEFT);
  assign own_r  = (owner_q == OWN_RIGHT);
  assign pend_l = req_l_q;
  assign pend_r = req_r_q;
endmodule

// File: rtl/sem_read_latch.sv
module sem_read_latch #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              held,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (rd_en) data_d = {DATA_W{!held}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '1;
    else        data_q <= data_d;
  end

  assign rdata = data_q;
endmodule

// File: rtl/sem_latch_bank.sv
module sem_latch_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_n,
  input  logic              l_ce_n,
  input  logic              l_we_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_n,
  input  logic              r_ce_n,
  input  logic              r_we_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int SEL_W = $clog2(NUM_SEM);

  logic               rst_int_n;
  logic [SEL_W-1:0]   l_sel, r_sel;
  logic [NUM_SEM-1:0] l_wr_hot, r_wr_hot;
  logic               l_rd_en, r_rd_en;
  logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r;
  logic               unused_hi_bits;

  assign l_sel = l_addr[SEL_W-1:0];
  assign r_sel = r_addr[SEL_W-1:0];
  assign unused_hi_bits = ^{l_addr[ADDR_W-1:SEL_W], r_addr[ADDR_W-1:SEL_W],
                            l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  sem_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  sem_port_decode #(.NUM_SEM(NUM_SEM), .SEL_W(SEL_W)) u_dec_l (
    .sem_n  (l_sem_n),
    .ce_n   (l_ce_n),
    .we_n   (l_we_n),
    .sel    (l_sel),
    .wr_hot (l_wr_hot),
    .rd_en  (l_rd_en)
  );

  sem_port_decode #(.NUM_SEM(NUM_SEM), .SEL_W(SEL_W)) u_dec_r (
    .sem_n  (r_sem_n),
    .ce_n   (r_ce_n),
    .we_n   (r_we_n),
    .sel    (r_sel),
    .wr_hot (r_wr_hot),
    .rd_en  (r_rd_en)
  );

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_cell
    sem_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr_l   (l_wr_hot[s]),
      .bit_l  (l_wdata[0]),
      .wr_r   (r_wr_hot[s]),
      .bit_r  (r_wdata[0]),
      .own_l  (own_l[s]),
      .own_r  (own_r[s]),
      .pend_l (pend_l[s]),
      .pend_r (pend_r[s])
    );
  end

  sem_read_latch #(.DATA_W(DATA_W)) u_rd_l (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rd_en (l_rd_en),
    .held  (own_l[l_sel]),
    .rdata (l_rdata)
  );

  sem_read_latch #(.DATA_W(DATA_W)) u_rd_r (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rd_en (r_rd_en),
    .held  (own_r[r_sel]),
    .rdata (r_rdata)
  );
endmodule

// File: rtl/sem_latch_bank_chk.sv
module sem_latch_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_sem_n,
  input logic               l_ce_n,
  input logic               l_we_n,
  input logic [ADDR_W-1:0]  l_addr,
  input logic [DATA_W-1:0]  l_wdata,
  input logic [DATA_W-1:0]  l_rdata,
  input logic               r_sem_n,
  input logic               r_ce_n,
  input logic               r_we_n,
  input logic [ADDR_W-1:0]  r_addr,
  input logic [DATA_W-1:0]  r_wdata,
  input logic [DATA_W-1:0]  r_rdata,
  input logic [NUM_SEM-1:0] own_l,
  input logic [NUM_SEM-1:0] own_r,
  input logic [NUM_SEM-1:0] pend_l,
  input logic [NUM_SEM-1:0] pend_r
);
  localparam int SEL_W = $clog2(NUM_SEM);

  logic             l_wr, l_rd, r_wr, r_rd, l_b, r_b;
  logic [SEL_W-1:0] l_a, r_a;

  assign l_wr = !l_sem_n && l_ce_n && !l_we_n;
  assign l_rd = !l_sem_n && l_ce_n && l_we_n;
  assign r_wr = !r_sem_n && r_ce_n && !r_we_n;
  assign r_rd = !r_sem_n && r_ce_n && r_we_n;
  assign l_a  = l_addr[SEL_W-1:0];
  assign r_a  = r_addr[SEL_W-1:0];
  assign l_b  = l_wdata[0];
  assign r_b  = r_wdata[0];

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_wr && !r_wr) |=> ($stable(own_l) && $stable(own_r))); // R2

  AST_RDATA_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_rdata)); // R9

  AST_RDATA_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(r_rdata)); // R9

  AST_RDATA_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(l_rdata) == 0 || $countones(l_rdata) == DATA_W)); // R9

  AST_READ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd |=> (l_rdata[0] == !$past(own_l[l_a]))); // R4

  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && r_wr && l_a == r_a && !l_b && !r_b && !own_l[l_a] && !own_r[l_a])
    |=> own_l[$past(l_a)]); // R10

  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_b && own_l[l_a] && pend_r[l_a] && !(r_wr && r_a == l_a && r_b))
    |=> own_r[$past(l_a)]); // R7

  AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_b && own_l[l_a] && !pend_r[l_a] && !(r_wr && r_a == l_a && !r_b))
    |=> (!own_l[$past(l_a)] && !own_r[$past(l_a)])); // R6

  AST_OUTSIDER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr && own_l[r_a] && !(l_wr && l_a == r_a)) |=> own_l[$past(r_a)]); // R5
endmodule

bind sem_latch_bank sem_latch_bank_chk #(
  .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .l_sem_n (l_sem_n),
  .l_ce_n  (l_ce_n),
  .l_we_n  (l_we_n),
  .l_addr  (l_addr),
  .l_wdata (l_wdata),
  .l_rdata (l_rdata),
  .r_sem_n (r_sem_n),
  .r_ce_n  (r_ce_n),
  .r_we_n  (r_we_n),
  .r_addr  (r_addr),
  .r_wdata (r_wdata),
  .r_rdata (r_rdata),
  .own_l   (own_l),
  .own_r   (own_r),
  .pend_l  (pend_l),
  .pend_r  (pend_r)
);

// File: tb/tb_sem_latch_bank.sv
`timescale 1ns/1ps
module tb_sem_latch_bank;
  localparam int NS = 8;
  localparam int AW = 16;
  localparam int DW = 18;
  // op codes: 0 idle, 1 write, 2 read, 3 access with memory enable low, 4 select high
  localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2, OP_CE = 3, OP_NOSEL = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          l_sem_n, l_ce_n, l_we_n, r_sem_n, r_ce_n, r_we_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model: holder 0 free, 1 left, 2 right; request flags per side
  int            m_own [NS];
  bit            m_ql  [NS];
  bit            m_qr  [NS];
  logic [DW-1:0] exp_l, exp_r;
  logic [12:0]   junk_a = 13'h15A3;
  logic [16:0]   junk_d = 17'h0F0F5;

  always #10 clk = ~clk;

  sem_latch_bank #(.NUM_SEM(NS), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_port(input int op, input int a, input bit b,
                            output logic sn, output logic cn, output logic wn,
                            output logic [AW-1:0] ad, output logic [DW-1:0] wd);
    sn = 1'b1; cn = 1'b1; wn = 1'b1;
    ad = {junk_a, 3'(a)};
    wd = {junk_d, b};
    case (op)
      OP_WR:    begin sn = 1'b0; wn = 1'b0; end
      OP_RD:    begin sn = 1'b0; end
      OP_CE:    begin sn = 1'b0; cn = 1'b0; wn = 1'b0; end
      OP_NOSEL: begin wn = 1'b0; end
      default:  ;
    endcase
  endtask

  task automatic model_step(input int lop, input int la, input bit lb,
                            input int rop, input int ra, input bit rb);
    if (lop == OP_RD) exp_l = (m_own[la] == 1) ? '0 : '1;
    if (rop == OP_RD) exp_r = (m_own[ra] == 2) ? '0 : '1;
    if (lop == OP_WR) m_ql[la] = !lb;
    if (rop == OP_WR) m_qr[ra] = !rb;
    for (int s = 0; s < NS; s++) begin
      if (m_own[s] == 1) begin
        if (!m_ql[s]) m_own[s] = m_qr[s] ? 2 : 0;
      end else if (m_own[s] == 2) begin
        if (!m_qr[s]) m_own[s] = m_ql[s] ? 1 : 0;
      end else begin
        m_own[s] = m_ql[s] ? 1 : (m_qr[s] ? 2 : 0);
      end
    end
  endtask

  task automatic cyc(input int lop, input int la, input bit lb,
                     input int rop, input int ra, input bit rb, input string tag);
    @(negedge clk);
    drive_port(lop, la, lb, l_sem_n, l_ce_n, l_we_n, l_addr, l_wdata);
    drive_port(rop, ra, rb, r_sem_n, r_ce_n, r_we_n, r_addr, r_wdata);
    @(posedge clk);
    #2;
    model_step(lop, la, lb, rop, ra, rb);
    check({tag, " left"},  l_rdata, exp_l);
    check({tag, " right"}, r_rdata, exp_r);
  endtask

  // read both views of one flag and compare
  task automatic peek(input int a, input string tag);
    cyc(OP_RD, a, 1'b0, OP_RD, a, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int s = 0; s < NS; s++) begin m_own[s] = 0; m_ql[s] = 1'b0; m_qr[s] = 1'b0; end
    exp_l = '1; exp_r = '1;
    rst_n = 1'b0;
    drive_port(OP_IDLE, 0, 1'b0, l_sem_n, l_ce_n, l_we_n, l_addr, l_wdata);
    drive_port(OP_IDLE, 0, 1'b0, r_sem_n, r_ce_n, r_we_n, r_addr, r_wdata);
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset left",  l_rdata, '1);
    check("R1 reset right", r_rdata, '1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int a = 0; a < NS; a++) peek(a, "R1 free after reset");

    // R4 R5 R6 with upper address/data junk (R3) on every flag, both directions
    for (int a = 0; a < NS; a++) begin
      junk_a = 13'(a * 911 + 7); junk_d = 17'(a * 5003 + 1);
      cyc(OP_WR, a, 1'b0, OP_IDLE, 0, 1'b0, "R4 left acquire");
      peek(a, "R4 left holds R3");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b1, "R5 right writes one");
      peek(a, "R5 holder kept");
      cyc(OP_WR, a, 1'b1, OP_IDLE, 0, 1'b0, "R6 left release");
      peek(a, "R6 both read one");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b0, "R4 right acquire");
      peek(a, "R4 right holds");
      cyc(OP_WR, a, 1'b1, OP_IDLE, 0, 1'b0, "R5 left writes one");
      peek(a, "R5 right kept");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b1, "R6 right release");
      peek(a, "R6 free again");
    end

    // R7 handover and R8 withdrawal on every flag
    for (int a = 0; a < NS; a++) begin
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b0, "R7 right acquire");
      cyc(OP_WR, a, 1'b0, OP_IDLE, 0, 1'b0, "R7 left queues");
      peek(a, "R7 left still out");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b1, "R7 right release");
      peek(a, "R7 left now holds");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b0, "R8 right queues");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b1, "R8 right withdraws");
      cyc(OP_WR, a, 1'b1, OP_IDLE, 0, 1'b0, "R8 left release");
      peek(a, "R8 flag free");
      // same-cycle release by holder and request by other side
      cyc(OP_WR, a, 1'b0, OP_IDLE, 0, 1'b0, "R7 left acquire");
      cyc(OP_WR, a, 1'b1, OP_WR, a, 1'b0, "R7 simultaneous");
      peek(a, "R7 right takes over");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b1, "R7 cleanup");
    end

    // R10 same-cycle tie, R11 independence
    for (int a = 0; a < NS; a++) begin
      cyc(OP_WR, a, 1'b0, OP_WR, a, 1'b0, "R10 tie");
      peek(a, "R10 left wins");
      for (int o = 0; o < NS; o++) if (o != a) peek(o, "R11 others free");
      cyc(OP_WR, a, 1'b1, OP_IDLE, 0, 1'b0, "R10 left release");
      peek(a, "R10 right handed flag");
      cyc(OP_IDLE, 0, 1'b0, OP_WR, a, 1'b1, "R10 cleanup");
    end

    // R2 blocked accesses: memory enable low, select high
    for (int a = 0; a < NS; a++) begin
      cyc(OP_CE, a, 1'b0, OP_NOSEL, a, 1'b0, "R2 blocked write");
      peek(a, "R2 still free");
      cyc(OP_WR, a, 1'b0, OP_IDLE, 0, 1'b0, "R2 left acquire");
      cyc(OP_NOSEL, a, 1'b1, OP_CE, a, 1'b0, "R2 blocked release");
      peek(a, "R2 still held");
      cyc(OP_WR, a, 1'b1, OP_IDLE, 0, 1'b0, "R2 cleanup");
    end

    // R9 latched read survives other port's writes
    cyc(OP_IDLE, 0, 1'b0, OP_WR, 5, 1'b0, "R9 right acquire");
    cyc(OP_RD, 5, 1'b0, OP_RD, 5, 1'b0, "R9 read views");
    cyc(OP_IDLE, 0, 1'b0, OP_WR, 5, 1'b1, "R9 right release after read");
    cyc(OP_CE, 5, 1'b0, OP_IDLE, 0, 1'b0, "R9 blocked read keeps data");
    cyc(OP_IDLE, 0, 1'b0, OP_IDLE, 0, 1'b0, "R9 hold");

    // R11 pseudo-random mix against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      int lo, ro;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lo = int'(lfsr[1:0]);
      ro = int'(lfsr[9:8]);
      junk_a = lfsr[12:0]; junk_d = {lfsr, lfsr[0]};
      cyc(lo, int'(lfsr[4:2]), lfsr[5], ro, int'(lfsr[12:10]), lfsr[13], "R11 random mix");
    end
    for (int a = 0; a < NS; a++) peek(a, "R11 final state");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule